// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Flag Unit

This block watches a small input port, eight pins by default, and raises a single interrupt request for the whole port when a chosen transition appears on any pin that software has enabled. Each pin has three bits: a flag, an edge-select bit and an enable bit, all reached through a simple register bus. The bus has a one-cycle write strobe, a two-bit offset, and read data that follows the offset in the same cycle. Pin inputs pass through a two-flop synchronizer. Edges are found by comparing the newest synchronized sample with the one taken a cycle earlier.

A flag stays set until software writes a zero to it. Servicing the interrupt does not clear it, and the acknowledge input from the interrupt controller leaves every flag untouched. Software can also write a one to a flag to raise a software-triggered request. The handler reads the flag register to learn which pin caused the request. Any flag that is still set, or that is set again during or after the handler, keeps the request asserted, so no edge goes unserviced.

Top module: `portedge_irq`

## Requirements
- R1: After a synchronous reset, all flag, edge-select and enable bits read 0 and irq_o is 0.
- R2: When a pin's edge-select bit is 0, a 0-to-1 change on that pin sets its flag. The new flag reads back after the third rising clock edge that follows the pin change.
- R3: When a pin's edge-select bit is 1, a 1-to-0 change on that pin sets its flag, with the same three-edge latency.
- R4: A pin held at a steady level never sets its flag. A transition in the direction that was not selected does not set it either.
- R5: irq_o is 1 exactly when at least one pin has both its flag bit and its enable bit set. All pins share this one output.
- R6: A flag bit is cleared only by a write of 0 to that bit at offset 0. irq_ack_i has no effect on any flag.
- R7: A write of 1 to a flag bit at offset 0 sets that flag, which raises irq_o if that pin is enabled.
- R8: If a software write of 0 and a detected edge reach the same flag in the same cycle, the flag ends up set.
- R9: The register offsets are 0 for flags, 1 for edge-select and 2 for enable. Bit i of each register belongs to pin i. Offset 3 reads as 0, and writes to it change nothing. Read data is combinational from bus_addr_i.
- R10: While any enabled flag stays set, irq_o stays 1. Clearing one flag leaves the request up if another enabled flag is still set, and an edge that arrives while a flag is already set keeps the request up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N_PINS | Asynchronous port pin levels |
| bus_wr_i | input | 1 | One-cycle register write strobe |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | N_PINS | Write data |
| bus_rdata_o | output | N_PINS | Read data for bus_addr_i (combinational) |
| irq_ack_i | input | 1 | Acknowledge from the interrupt controller; flags are not affected |
| irq_o | output | 1 | Combined port interrupt request |

## Verification
A wrong flag state shows up in two places: in the value read at offset 0 on the next read, and on irq_o in the same cycle for any enabled pin. A lost or spurious edge is therefore visible three clock edges after the pin change. The bench sweeps every pin in both edge directions, and it checks irq_o against all 256 enable patterns over a fixed flag pattern. It also covers the cases where an internal race would hide a fault: a clear and an edge arriving together, acknowledges sent with no clearing write, and writes to the unused offset.

// File: rtl/portedge_pkg.sv
package portedge_pkg;

    typedef enum logic [1:0] {
        OFS_FLAG = 2'd0,
        OFS_EDGE = 2'd1,
        OFS_MASK = 2'd2,
        OFS_NONE = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic flag_we;
        logic edge_we;
        logic mask_we;
    } bank_we_t;

    function automatic bank_we_t decode_write(input logic wr, input reg_ofs_e ofs);
        bank_we_t we;
        we.flag_we = wr && (ofs == OFS_FLAG);
        we.edge_we = wr && (ofs == OFS_EDGE);
        we.mask_we = wr && (ofs == OFS_MASK);
        return we;
    endfunction

    // select = 0 : rising transition, select = 1 : falling transition
    function automatic logic edge_pick(input logic now_v, input logic was_v, input logic select);
        return select ? (was_v & ~now_v) : (now_v & ~was_v);
    endfunction

endpackage

// File: rtl/portedge_sync.sv
module portedge_sync #(
    parameter int N_PINS = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] raw_i,
    output logic [N_PINS-1:0] sync_o
);
    logic [N_PINS-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= raw_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/portedge_detect.sv
module portedge_detect
    import portedge_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] sync_i,
    input  logic [N_PINS-1:0] edge_sel_i,
    output logic [N_PINS-1:0] hit_o
);
    logic [N_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sync_i;
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        assign hit_o[i] = edge_pick(sync_i[i], prev_q[i], edge_sel_i[i]);
    end
endmodule

// File: rtl/portedge_bank.sv
module portedge_bank
    import portedge_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_we_t          we_i,
    input  logic [N_PINS-1:0] wdata_i,
    input  logic [N_PINS-1:0] hit_i,
    output logic [N_PINS-1:0] flag_o,
    output logic [N_PINS-1:0] edge_sel_o,
    output logic [N_PINS-1:0] mask_o
);
    logic [N_PINS-1:0] flag_q, edge_q, mask_q;
    logic [N_PINS-1:0] flag_d;

    // hardware set is applied after the software value: an edge is never lost
    always_comb begin
        flag_d = we_i.flag_we ? wdata_i : flag_q;
        flag_d = flag_d | hit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            edge_q <= '0;
            mask_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (we_i.edge_we) edge_q <= wdata_i;
            if (we_i.mask_we) mask_q <= wdata_i;
        end
    end

    assign flag_o     = flag_q;
    assign edge_sel_o = edge_q;
    assign mask_o     = mask_q;
endmodule

// File: rtl/portedge_irq.sv
module portedge_irq
    import portedge_pkg::*;
#(
    parameter int N_PINS      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [N_PINS-1:0] bus_wdata_i,
    output logic [N_PINS-1:0] bus_rdata_o,
    input  logic              irq_ack_i,
    output logic              irq_o
);
    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] hit;
    logic [N_PINS-1:0] flag_q, edge_q, mask_q;
    reg_ofs_e          ofs;
    bank_we_t          we;

    assign ofs = reg_ofs_e'(bus_addr_i);
    assign we  = decode_write(bus_wr_i, ofs);

    portedge_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw_i(pin_i), .sync_o(pin_sync)
    );

    portedge_detect #(.N_PINS(N_PINS)) u_detect (
        .clk(clk), .rst(rst), .sync_i(pin_sync), .edge_sel_i(edge_q), .hit_o(hit)
    );

    portedge_bank #(.N_PINS(N_PINS)) u_bank (
        .clk(clk), .rst(rst), .we_i(we), .wdata_i(bus_wdata_i), .hit_i(hit),
        .flag_o(flag_q), .edge_sel_o(edge_q), .mask_o(mask_q)
    );

    always_comb begin
        unique case (ofs)
            OFS_FLAG: bus_rdata_o = flag_q;
            OFS_EDGE: bus_rdata_o = edge_q;
            OFS_MASK: bus_rdata_o = mask_q;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign irq_o = |(flag_q & mask_q);
endmodule

// File: rtl/portedge_irq_chk.sv
module portedge_irq_chk #(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr_i,
    input logic [1:0]        bus_addr_i,
    input logic              irq_ack_i,
    input logic              irq_o,
    input logic [N_PINS-1:0] hit,
    input logic [N_PINS-1:0] flag_q,
    input logic [N_PINS-1:0] edge_q,
    input logic [N_PINS-1:0] mask_q
);
    logic flag_wr, edge_wr, mask_wr;
    assign flag_wr = bus_wr_i && (bus_addr_i == 2'd0);
    assign edge_wr = bus_wr_i && (bus_addr_i == 2'd1);
    assign mask_wr = bus_wr_i && (bus_addr_i == 2'd2);

    // R2 R3 R8: a detected edge always leaves its flag set
    assert_edge_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((flag_q & $past(hit)) == $past(hit)));

    // R4: without a flag write, no flag rises unless an edge was detected
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> ((flag_q & ~$past(flag_q) & ~$past(hit)) == '0));

    // R6: without a flag write, no flag falls
    assert_no_auto_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> ((~flag_q & $past(flag_q)) == '0));

    // R6: acknowledge alone keeps every flag
    assert_ack_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_ack_i && !bus_wr_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R10: with no bus write the request can not drop
    assert_irq_held_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_i |=> !$fell(irq_o));

    // R9: edge-select and enable change only through their own offsets
    assert_edge_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !edge_wr |=> $stable(edge_q));
    assert_mask_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q));
endmodule

bind portedge_irq portedge_irq_chk #(.N_PINS(N_PINS)) u_chk (
    .clk(clk), .rst(rst), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .irq_ack_i(irq_ack_i), .irq_o(irq_o), .hit(hit), .flag_q(flag_q),
    .edge_q(edge_q), .mask_q(mask_q)
);

// File: tb/portedge_irq_tb.sv
`timescale 1ns/1ps
module portedge_irq_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_i = '0;
    logic         bus_wr_i = 1'b0;
    logic [1:0]   bus_addr_i = 2'd0;
    logic [N-1:0] bus_wdata_i = '0;
    logic [N-1:0] bus_rdata_o;
    logic         irq_ack_i = 1'b0;
    logic         irq_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    portedge_irq #(.N_PINS(N)) u_dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .bus_wr_i(bus_wr_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_ack_i(irq_ack_i), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr_i = a;
        #1 d = bus_rdata_o;
    endtask

    task automatic settle3();
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        checks++; fails++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [N-1:0] d;
        logic [N-1:0] exp;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        rd(2'd0, d); check("R1 flag", d, '0);
        rd(2'd1, d); check("R1 edge", d, '0);
        rd(2'd2, d); check("R1 mask", d, '0);
        check("R1 irq", {7'd0, irq_o}, '0);

        // R2 R3 R4: sweep every pin in both edge directions
        for (int i = 0; i < N; i++) begin
            for (int s = 0; s < 2; s++) begin
                wr(2'd1, (s == 1) ? (N'(1) << i) : '0);
                wr(2'd0, '0);
                @(negedge clk) pin_i[i] = 1'b1;
                settle3();
                rd(2'd0, d);
                exp = (s == 0) ? (N'(1) << i) : '0;
                check(s == 0 ? "R2 rise sets" : "R4 rise ignored", d, exp);
                repeat (4) @(posedge clk);
                rd(2'd0, d);
                check("R4 steady high", d, exp);
                @(negedge clk) pin_i[i] = 1'b0;
                settle3();
                rd(2'd0, d);
                exp = N'(1) << i;
                check(s == 1 ? "R3 fall sets" : "R2 fall ignored kept", d, exp);
            end
        end
        wr(2'd1, '0);
        wr(2'd0, '0);

        // R7: software set
        wr(2'd0, 8'hA5);
        rd(2'd0, d); check("R7 sw set", d, 8'hA5);

        // R5: exhaustive enable sweep over fixed flags
        for (int e = 0; e < 256; e++) begin
            wr(2'd2, N'(e));
            #1 check("R5 irq", {7'd0, irq_o}, {7'd0, |(8'hA5 & N'(e))});
        end

        // R6: partial clear and acknowledge without effect
        wr(2'd0, 8'h05);
        rd(2'd0, d); check("R6 partial clear", d, 8'h05);
        wr(2'd2, 8'h01);
        @(negedge clk) irq_ack_i = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) irq_ack_i = 1'b0;
        rd(2'd0, d); check("R6 ack keeps flags", d, 8'h05);
        check("R6 irq after ack", {7'd0, irq_o}, 8'h01);

        // R10: request persists while another enabled flag stays set
        wr(2'd2, 8'h05);
        wr(2'd0, 8'h04);
        #1 check("R10 other flag holds irq", {7'd0, irq_o}, 8'h01);
        @(negedge clk) pin_i[0] = 1'b1;
        settle3();
        rd(2'd0, d); check("R10 edge during handler", d, 8'h05);
        wr(2'd0, 8'h01);
        #1 check("R10 irq re-raised", {7'd0, irq_o}, 8'h01);
        wr(2'd0, '0);
        #1 check("R10 irq drops", {7'd0, irq_o}, 8'h00);

        // R8: clear and edge in the same cycle
        @(negedge clk) pin_i[3] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = 2'd0; bus_wdata_i = '0;
        @(negedge clk) bus_wr_i = 1'b0;
        rd(2'd0, d); check("R8 edge beats clear", d, 8'h08);

        // R9: unused offset
        wr(2'd1, 8'h3C);
        wr(2'd3, 8'hFF);
        rd(2'd3, d); check("R9 offset3 reads 0", d, '0);
        rd(2'd1, d); check("R9 edge unchanged", d, 8'h3C);
        rd(2'd2, d); check("R9 mask unchanged", d, 8'h05);
        rd(2'd0, d); check("R9 flag unchanged", d, 8'h08);

        finish_run();
    end
endmodule